// File: doc/BRIEF.md
# Translation lookaside buffer

This block caches page table entries so that a virtual page number can be turned into a physical frame number without a memory access. Each slot holds a virtual page number tag, a frame number and a few permission bits. Every valid slot is searched at once. A lookup presents a page number and gets back a hit flag, the frame number and the permissions in the same cycle.

When a lookup misses, the block reports it in one of two ways, chosen by a mode input. In hardware-walk mode it asks an external page table walker to fetch the entry. In software-managed mode it raises a miss fault for system software to handle. Either way, a new entry enters only through the refill port, which writes a tag together with its entry. A flush input drops every cached translation.

Top module: `tlb_cache`

## Requirements
- R1: After reset, or in the cycle after `flush_i` is high, every lookup misses. A refill presented in the same cycle as a flush is discarded.
- R2: A lookup whose page number matches a valid slot returns `lkp_hit_o`=1 and that slot's frame number and permissions in the same cycle.
- R3: On a miss, `lkp_pfn_o` and `lkp_perm_o` are zero.
- R4: With `sw_mode_i`=0, a missing lookup drives `walk_req_o`=1 and `miss_fault_o`=0.
- R5: With `sw_mode_i`=1, a missing lookup drives `miss_fault_o`=1 and `walk_req_o`=0.
- R6: With `lkp_valid_i`=0, `lkp_hit_o`, `walk_req_o` and `miss_fault_o` are all 0.
- R7: A refill (flush low) becomes visible to lookups from the next cycle on.
- R8: A lookup and a refill of the same page number in the same cycle report a miss, with the miss signalled according to the mode.
- R9: A refill whose tag matches a valid slot overwrites that slot in place and leaves every other slot unchanged.
- R10: While free slots remain, a refill takes the lowest-numbered free slot, so up to `ENTRIES` distinct tags stay resident together.
- R11: When all slots are valid, a refill of a new tag evicts the slot under a round-robin pointer. The pointer starts at slot 0 after reset or flush and advances by one, wrapping, after each such eviction.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all slots |
| sw_mode_i | input | 1 | 1 = software-managed misses, 0 = hardware walk |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup page number |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_pfn_o | output | PFN_W | Frame number of the hit |
| lkp_perm_o | output | PERM_W | Permission bits of the hit |
| walk_req_o | output | 1 | Miss, hardware walk requested |
| miss_fault_o | output | 1 | Miss, software fault raised |
| fill_valid_i | input | 1 | Refill write |
| fill_vpn_i | input | VPN_W | Refill page number |
| fill_pfn_i | input | PFN_W | Refill frame number |
| fill_perm_i | input | PERM_W | Refill permission bits |

## Verification
Directed sequences fill every slot in order and then keep refilling. This separates lowest-free placement from round-robin eviction and shows which old tag is lost at each step. Overwrite-in-place and same-cycle lookup/refill collisions are applied explicitly, as is a flush coinciding with a refill. A random stream with a narrow page-number space follows. It mixes hits on resident tags, misses, repeated tags and mode changes, so that the miss-reporting path of each mode is checked against a reference model.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              sw_mode_i,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  output logic              lkp_hit_o,
  output logic [PFN_W-1:0]  lkp_pfn_o,
  output logic [PERM_W-1:0] lkp_perm_o,
  output logic              walk_req_o,
  output logic              miss_fault_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PERM_W-1:0] fill_perm_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] lk_match, fl_match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (tag_q[g] == lkp_vpn_i);
    assign fl_match[g] = vld_q[g] && (tag_q[g] == fill_vpn_i);
  end

  wire collide = fill_valid_i && (fill_vpn_i == lkp_vpn_i);
  wire miss    = lkp_valid_i && !lkp_hit_o;

  assign lkp_hit_o    = lkp_valid_i && (|lk_match) && !collide;
  assign walk_req_o   = miss && !sw_mode_i;
  assign miss_fault_o = miss && sw_mode_i;

  logic [PFN_W-1:0]  sel_pfn;
  logic [PERM_W-1:0] sel_perm;
  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) begin
        sel_pfn  = sel_pfn  | pfn_q[i];
        sel_perm = sel_perm | perm_q[i];
      end
  end
  assign lkp_pfn_o  = lkp_hit_o ? sel_pfn  : '0;
  assign lkp_perm_o = lkp_hit_o ? sel_perm : '0;

  logic [IDX_W-1:0] vic;
  logic             use_rr;
  always_comb begin
    vic    = rr_q;
    use_rr = 1'b0;
    if (|fl_match) begin
      for (int i = 0; i < ENTRIES; i++)
        if (fl_match[i]) vic = IDX_W'(i);
    end else if (&vld_q) begin
      use_rr = 1'b1;
    end else begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!vld_q[i]) vic = IDX_W'(i);
    end
  end

  wire do_fill = fill_valid_i && !flush_i;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_valid_i) begin
      vld_q[vic] <= 1'b1;
      if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_fill) begin
      tag_q[vic]  <= fill_vpn_i;
      pfn_q[vic]  <= fill_pfn_i;
      perm_q[vic] <= fill_perm_i;
    end
  end

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !lkp_hit_o);

  a_r8_collision_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && fill_valid_i && fill_vpn_i == lkp_vpn_i) |-> !lkp_hit_o);

  a_r4_hw_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode_i |-> !miss_fault_o);

  a_r5_sw_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode_i |-> !walk_req_o);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid_i |-> !(lkp_hit_o || walk_req_o || miss_fault_o));

  a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid_i && !flush_i && rst_n) && lkp_valid_i && !fill_valid_i &&
     lkp_vpn_i == $past(fill_vpn_i)) |-> (lkp_hit_o && lkp_pfn_o == $past(fill_pfn_i)));

  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_hit_o |-> (lkp_pfn_o == '0 && lkp_perm_o == '0));
endmodule

// File: tb/tlb_cache_tb.sv
`timescale 1ns/1ps
module tlb_cache_tb_top;
  localparam int N = 4, VW = 6, PW = 8, MW = 3;

  logic clk = 0, rst_n = 0;
  logic flush_i = 0, sw_mode_i = 0, lkp_valid_i = 0, fill_valid_i = 0;
  logic [VW-1:0] lkp_vpn_i = 0, fill_vpn_i = 0;
  logic [PW-1:0] fill_pfn_i = 0;
  logic [MW-1:0] fill_perm_i = 0;
  logic lkp_hit_o, walk_req_o, miss_fault_o;
  logic [PW-1:0] lkp_pfn_o;
  logic [MW-1:0] lkp_perm_o;

  tlb_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .PERM_W(MW)) dut_i (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic          m_v [N];
  logic [VW-1:0] m_t [N];
  logic [PW-1:0] m_p [N];
  logic [MW-1:0] m_m [N];
  int            m_rr;

  function automatic int m_find(logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == v) return i;
    return -1;
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endfunction

  function automatic void m_fill(logic [VW-1:0] v, logic [PW-1:0] p, logic [MW-1:0] m);
    int k = m_find(v);
    if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
    if (k < 0) begin k = m_rr; m_rr = (m_rr + 1) % N; end
    m_v[k] = 1; m_t[k] = v; m_p[k] = p; m_m[k] = m;
  endfunction

  task automatic step(string rq, bit fl, bit sw, bit lv, logic [VW-1:0] lvpn,
                      bit fv, logic [VW-1:0] fvpn, logic [PW-1:0] fp, logic [MW-1:0] fm);
    int k;
    bit eh, ew, ef;
    logic [PW-1:0] ep;
    logic [MW-1:0] em;
    flush_i = fl; sw_mode_i = sw; lkp_valid_i = lv; lkp_vpn_i = lvpn;
    fill_valid_i = fv; fill_vpn_i = fvpn; fill_pfn_i = fp; fill_perm_i = fm;
    #1;
    k  = m_find(lvpn);
    eh = lv && k >= 0 && !(fv && fvpn == lvpn);
    ep = eh ? m_p[k] : '0;
    em = eh ? m_m[k] : '0;
    ew = lv && !eh && !sw;
    ef = lv && !eh && sw;
    checks++;
    if (lkp_hit_o !== eh || lkp_pfn_o !== ep || lkp_perm_o !== em ||
        walk_req_o !== ew || miss_fault_o !== ef) begin
      fails++;
      $display("FAIL %s: got hit=%0b pfn=%0h perm=%0h walk=%0b fault=%0b, exp hit=%0b pfn=%0h perm=%0h walk=%0b fault=%0b",
               rq, lkp_hit_o, lkp_pfn_o, lkp_perm_o, walk_req_o, miss_fault_o, eh, ep, em, ew, ef);
    end
    @(posedge clk);
    if (fl) m_clear();
    else if (fv) m_fill(fvpn, fp, fm);
    @(negedge clk);
  endtask

  task automatic look(string rq, bit sw, logic [VW-1:0] v);
    step(rq, 0, sw, 1, v, 0, 0, 0, 0);
  endtask

  task automatic fill(string rq, logic [VW-1:0] v, logic [PW-1:0] p);
    step(rq, 0, 0, 0, 0, 1, v, p, MW'(p));
  endtask

  initial begin
    m_clear();
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    rst_n = 1;
    look("R1 reset empty", 0, 6'd1);
    step("R6 idle", 0, 1, 0, 6'd1, 0, 0, 0, 0);
    fill("R7 fill", 6'd10, 8'hA0);
    look("R7 visible next cycle", 0, 6'd10);
    fill("R10 fill", 6'd11, 8'hA1);
    fill("R10 fill", 6'd12, 8'hA2);
    fill("R10 fill", 6'd13, 8'hA3);
    for (int i = 0; i < N; i++) look("R10 all resident R2", 0, VW'(10 + i));
    look("R3 R4 miss hw", 0, 6'd40);
    look("R5 miss sw", 1, 6'd40);
    fill("R11 evict slot0", 6'd20, 8'hB0);
    look("R11 evicted first", 0, 6'd10);
    look("R11 second kept", 0, 6'd11);
    fill("R11 evict slot1", 6'd21, 8'hB1);
    look("R11 evicted second", 1, 6'd11);
    fill("R9 overwrite", 6'd12, 8'hC2);
    look("R9 new data", 0, 6'd12);
    look("R9 neighbour kept", 0, 6'd13);
    look("R9 neighbour kept", 0, 6'd20);
    fill("R11 pointer unmoved by overwrite", 6'd22, 8'hB2);
    look("R11 slot2 evicted", 0, 6'd12);
    step("R8 collision hw", 0, 0, 1, 6'd30, 1, 6'd30, 8'hD0, 3'd5);
    look("R8 visible after", 0, 6'd30);
    step("R8 collision sw existing tag", 0, 1, 1, 6'd30, 1, 6'd30, 8'hD1, 3'd6);
    look("R8 overwrite landed", 0, 6'd30);
    step("R1 flush with fill", 1, 0, 1, 6'd30, 1, 6'd31, 8'hE0, 3'd1);
    look("R1 flushed", 0, 6'd30);
    look("R1 fill dropped", 1, 6'd31);
    fill("R11 restart", 6'd1, 8'h01);
    for (int c = 0; c < 3000; c++) begin
      bit fl, sw, lv, fv;
      logic [VW-1:0] lvpn, fvpn;
      int pick;
      fl = ($urandom % 40) == 0;
      sw = ((c / 50) % 2) == 1;
      lv = ($urandom % 4) != 0;
      fv = ($urandom % 3) == 0;
      fvpn = VW'($urandom % 12);
      pick = $urandom % N;
      lvpn = (($urandom % 2) && m_v[pick]) ? m_t[pick] : VW'($urandom % 12);
      step(sw ? "R2 R5 R9 R11 random" : "R2 R4 R9 R11 random",
           fl, sw, lv, lvpn, fv, fvpn, PW'($urandom), MW'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule